// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an external 128K x 8 asynchronous static RAM. The RAM is controlled by two chip selects of opposite polarity (an active-low one and an active-high one), an active-low write enable and an active-low output enable. The host raises a request with a direction flag, a 17-bit address and, for writes, a data byte. The controller registers them and then plays out the RAM's strobe sequence. Every strobe comes straight from a flop. Each phase length is a whole number of clock cycles, derived at elaboration from nanosecond minimums and the clock period, rounded up.

A read keeps both selects active and the output enable low for the full access window. It then samples the RAM data bus in a final capture cycle. A write has a one-cycle setup with both selects active. Then comes a write-enable pulse while the external tri-state buffer drives the data. A trailing cycle pads the access to the minimum cycle time. A one-cycle done pulse marks the end of each access.

A separate standby input parks the RAM deselected so that it can hold its data at low power. When standby is released, the controller waits a full read-cycle time before it accepts any new access.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows busy=0, done=0, rdata=0, mem_cs1_n=1, mem_cs2=0, mem_we_n=1, mem_oe_n=1, mem_doe=0.
- R2: When no access, standby or recovery is in progress, the RAM is deselected (mem_cs1_n=1, mem_cs2=0), with mem_we_n=1, mem_oe_n=1, mem_doe=0 and busy=0.
- R3: A read accepted at an edge (request high, write flag low, controller idle, standby low) drives mem_cs1_n=0, mem_cs2=1, mem_oe_n=0, mem_we_n=1 and busy=1 for RD+1 cycles. RD is the larger of the rounded-up cycle time and the rounded-up output-enable access time (7+1 cycles at the defaults).
- R4: rdata takes the value on mem_din in the last active read cycle. In the cycle after that, done=1 and busy=0, and rdata then holds until the next read completes.
- R5: A write accepted at an edge gives one setup cycle (selects active, mem_we_n=1), then WP cycles with mem_we_n=0, mem_doe=1 and mem_dout equal to the request data, then WE cycles with mem_we_n=1 and mem_doe=0. mem_oe_n stays 1 throughout, and done=1 follows in the next cycle.
- R6: WP is the largest of the rounded-up write-pulse, data-setup and (chip-select-to-end-of-write minus one) counts. The whole selected window of any access is at least the rounded-up cycle time, so WE = max(1, cycle - 1 - WP) (WP=5, WE=1 at the defaults).
- R7: done is high for exactly one cycle per access, and busy is high from the cycle after acceptance until done rises.
- R8: A request raised while busy is not accepted and leaves no trace if it is withdrawn before the controller is idle again.
- R9: If standby is high at an idle edge, the controller enters standby, taking priority over a simultaneous request. In standby it keeps the RAM deselected, with busy=1, for as long as standby stays high.
- R10: When standby falls, the controller stays deselected and busy for a full rounded-up read-cycle time (7 cycles at the defaults). It then has one idle cycle before a pending request can be accepted.
- R11: mem_addr and mem_dout keep the values captured at acceptance for the whole access, whatever the host does to req_addr and req_wdata meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Host access request, held until accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Host word address |
| req_wdata | input | 8 | Host write data |
| standby_req | input | 1 | Request low-power data retention |
| busy | output | 1 | Controller not idle |
| done | output | 1 | One-cycle end-of-access pulse |
| rdata | output | 8 | Last read result |
| mem_addr | output | 17 | RAM address |
| mem_dout | output | 8 | Data toward the RAM |
| mem_doe | output | 1 | Enable for the external data driver |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_din | input | 8 | Data from the RAM |

## Verification
A wrong phase of the sequencer shows up at the strobe pins in the same cycle as a select, enable or busy pattern that differs from the expected one. A phase counter that is off by one shows up as a pulse or window that is one cycle short or long; this is visible at the first edge where the strobe should have changed. A broken write path shows up only later, as a wrong rdata in the done cycle of a read of that address. A broken hold register shows up as a mem_addr that tracks the host inputs in the middle of an access.

// File: rtl/sramc_pkg.sv
// Shared types and elaboration helpers for the SRAM cycle controller.
// Assumes: all timing arguments are non-negative integers in ns.
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_WAIT,
        ST_RD_CAPT,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_END,
        ST_STANDBY,
        ST_RECOVER
    } sramc_state_e;

    // Integer division rounded up.
    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sramc_span_counter.sv
// Down-counter that times one phase of the sequencer.
// Assumes: load_val is the phase length minus one; expired is high
// in the last cycle of the phase.
module sramc_span_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load at phase entry, then count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sramc_seq.sv
// Access sequencer: picks the next phase, times each phase with a
// span counter and issues accept, capture and done.
// Assumes: phase lengths are at least one cycle; requests are held by
// the host until accepted.
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int RD_CYC   = 7,
    parameter int WP_CYC   = 5,
    parameter int WEND_CYC = 1,
    parameter int REC_CYC  = 7,
    parameter int CNT_W    = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         req,
    input  logic         req_write,
    input  logic         standby_req,
    output sramc_state_e state_q,
    output sramc_state_e state_d,
    output logic         accept,
    output logic         capture,
    output logic         done
);

    logic             expired;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             done_q;
    logic [15:0]      rec_run;

    sramc_span_counter #(.CNT_W(CNT_W)) u_span (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .expired  (expired)
    );

    assign accept  = (state_q == ST_IDLE) && !standby_req && req;
    assign capture = (state_q == ST_RD_CAPT);

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (standby_req)      state_d = ST_STANDBY;
                else if (req)         state_d = req_write ? ST_WR_SETUP : ST_RD_WAIT;
            end
            ST_RD_WAIT:  if (expired) state_d = ST_RD_CAPT;
            ST_RD_CAPT:               state_d = ST_IDLE;
            ST_WR_SETUP:              state_d = ST_WR_PULSE;
            ST_WR_PULSE: if (expired) state_d = ST_WR_END;
            ST_WR_END:   if (expired) state_d = ST_IDLE;
            ST_STANDBY:  if (!standby_req) state_d = ST_RECOVER;
            ST_RECOVER:  if (expired) state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // Phase length loaded on every phase change.
    always_comb begin
        ld     = (state_d != state_q);
        ld_val = '0;
        case (state_d)
            ST_RD_WAIT:  ld_val = CNT_W'(RD_CYC - 1);
            ST_WR_PULSE: ld_val = CNT_W'(WP_CYC - 1);
            ST_WR_END:   ld_val = CNT_W'(WEND_CYC - 1);
            ST_RECOVER:  ld_val = CNT_W'(REC_CYC - 1);
            default:     ld_val = '0;
        endcase
    end

    // Phase register and end-of-access pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_RD_CAPT) || ((state_q == ST_WR_END) && expired);
        end
    end

    assign done = done_q;

    // Length of the current recovery phase, for the checker below.
    always_ff @(posedge clk) begin
        if (!rst_n)                    rec_run <= '0;
        else if (state_q == ST_RECOVER) rec_run <= rec_run + 1'b1;
        else                           rec_run <= '0;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_RECOVER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_RECOVER && state_q != ST_RECOVER) |-> (rec_run == 16'(REC_CYC))); // R10

endmodule

// File: rtl/sramc_pins.sv
// Memory-side registers: strobes registered from the next phase so
// they never glitch, plus held address, write data and read result.
// Assumes: state_d is the sequencer's next phase for the same edge.
module sramc_pins
    import sramc_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int WP_CYC = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sramc_state_e      state_d,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_din,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_doe,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] rdata
);

    logic        sel_d, we_d, oe_d;
    logic [15:0] we_run;

    // Strobe decode of the next phase.
    always_comb begin
        sel_d = (state_d == ST_RD_WAIT)  || (state_d == ST_RD_CAPT) ||
                (state_d == ST_WR_SETUP) || (state_d == ST_WR_PULSE) ||
                (state_d == ST_WR_END);
        we_d  = (state_d == ST_WR_PULSE);
        oe_d  = (state_d == ST_RD_WAIT) || (state_d == ST_RD_CAPT);
    end

    // Registered strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cs1_n <= 1'b1;
            mem_cs2   <= 1'b0;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_doe   <= 1'b0;
        end else begin
            mem_cs1_n <= !sel_d;
            mem_cs2   <= sel_d;
            mem_we_n  <= !we_d;
            mem_oe_n  <= !oe_d;
            mem_doe   <= we_d;
        end
    end

    // Address and write data held from acceptance to the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            mem_dout <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            mem_dout <= req_wdata;
        end
    end

    // Read result sampled in the capture cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata <= '0;
        else if (capture) rdata <= mem_din;
    end

    // Width of the current write pulse, for the checker below.
    always_ff @(posedge clk) begin
        if (!rst_n)        we_run <= '0;
        else if (!mem_we_n) we_run <= we_run + 1'b1;
        else               we_run <= '0;
    end

    AST_WE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs1_n && mem_cs2)); // R5
    AST_NO_OE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n)); // R5
    AST_WE_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_run >= 16'(WP_CYC))); // R6
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs1_n && $past(!mem_cs1_n)) |-> ($stable(mem_addr) && $stable(mem_dout))); // R11

endmodule

// File: rtl/sram_cycle_ctrl.sv
// Top of the asynchronous SRAM cycle controller. Converts ns timing
// minimums to cycle counts and joins the sequencer and pin registers.
// Assumes: CLK_PERIOD_NS > 0; host holds req until it is accepted.
module sram_cycle_ctrl
    import sramc_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_CYCLE_NS    = 70,
    parameter int T_OE_NS       = 40,
    parameter int T_WP_NS       = 50,
    parameter int T_CW_NS       = 60,
    parameter int T_DW_NS       = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              standby_req,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_doe,
    output logic              mem_cs1_n,
    output logic              mem_cs2,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    input  logic [DATA_W-1:0] mem_din
);

    localparam int RC_CYC   = imax(1, cdiv(T_CYCLE_NS, CLK_PERIOD_NS));
    localparam int OE_CYC   = imax(1, cdiv(T_OE_NS, CLK_PERIOD_NS));
    localparam int WPR_CYC  = imax(1, cdiv(T_WP_NS, CLK_PERIOD_NS));
    localparam int CW_CYC   = imax(1, cdiv(T_CW_NS, CLK_PERIOD_NS));
    localparam int DW_CYC   = imax(1, cdiv(T_DW_NS, CLK_PERIOD_NS));
    localparam int RD_CYC   = imax(RC_CYC, OE_CYC);
    localparam int WP_CYC   = imax(imax(WPR_CYC, DW_CYC), imax(CW_CYC - 1, 1));
    localparam int WEND_CYC = imax(1, RC_CYC - 1 - WP_CYC);
    localparam int REC_CYC  = RC_CYC;
    localparam int CNT_MAX  = imax(imax(RD_CYC, WP_CYC), imax(WEND_CYC, REC_CYC));
    localparam int CNT_W    = imax(1, $clog2(CNT_MAX + 1));

    sramc_state_e state_q, state_d;
    logic         accept, capture;

    sramc_seq #(
        .RD_CYC   (RD_CYC),
        .WP_CYC   (WP_CYC),
        .WEND_CYC (WEND_CYC),
        .REC_CYC  (REC_CYC),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .req_write   (req_write),
        .standby_req (standby_req),
        .state_q     (state_q),
        .state_d     (state_d),
        .accept      (accept),
        .capture     (capture),
        .done        (done)
    );

    sramc_pins #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .WP_CYC (WP_CYC)
    ) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .state_d   (state_d),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .mem_din   (mem_din),
        .mem_addr  (mem_addr),
        .mem_dout  (mem_dout),
        .mem_doe   (mem_doe),
        .mem_cs1_n (mem_cs1_n),
        .mem_cs2   (mem_cs2),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .rdata     (rdata)
    );

    assign busy = (state_q != ST_IDLE);

    AST_STANDBY_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STANDBY || state_q == ST_RECOVER) |-> (mem_cs1_n && !mem_cs2 && busy)); // R9
    AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_cs1_n && !mem_cs2 && mem_we_n && mem_oe_n && !mem_doe)); // R2

endmodule

// File: tb/sim_sram_cycle_ctrl.sv
// Bench: a queue-based expected-pin model plus a byte-array RAM model.
module sim_sram_cycle_ctrl;

    localparam int CLK_NS = 10;
    localparam int RCMIN  = (70 + CLK_NS - 1) / CLK_NS;
    localparam int OEMIN  = (40 + CLK_NS - 1) / CLK_NS;
    localparam int WPMIN  = (50 + CLK_NS - 1) / CLK_NS;
    localparam int CWMIN  = (60 + CLK_NS - 1) / CLK_NS;
    localparam int DWMIN  = (30 + CLK_NS - 1) / CLK_NS;
    localparam int RDN    = (RCMIN > OEMIN) ? RCMIN : OEMIN;
    localparam int WPN    = (WPMIN > DWMIN) ? ((WPMIN > CWMIN - 1) ? WPMIN : CWMIN - 1)
                                            : ((DWMIN > CWMIN - 1) ? DWMIN : CWMIN - 1);
    localparam int WEN    = (RCMIN - 1 - WPN > 1) ? RCMIN - 1 - WPN : 1;

    // {busy, done, cs1_n, cs2, we_n, oe_n, doe}
    localparam logic [6:0] P_IDLE = 7'b0010110;
    localparam logic [6:0] P_DONE = 7'b0110110;
    localparam logic [6:0] P_RD   = 7'b1001100;
    localparam logic [6:0] P_WSET = 7'b1001110;
    localparam logic [6:0] P_WPUL = 7'b1001011;
    localparam logic [6:0] P_SB   = 7'b1010110;

    typedef struct {
        logic [6:0]  pins;
        logic [16:0] addr;
        logic [7:0]  dout;
        logic        set_rd;
        logic [7:0]  rd;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, req_write = 1'b0, standby_req = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done, mem_doe, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n;
    logic [7:0]  rdata, mem_dout;
    logic [16:0] mem_addr;
    logic [7:0]  mem_din = 8'h00;

    int checks = 0, errors = 0, cyc = 0;
    bit started = 0;

    exp_t        q[$];
    exp_t        cur;
    logic [7:0]  exp_rdata = 8'h00;
    bit          in_sb = 0, last_busy = 0, acc_evt = 0;
    logic [7:0]  ram [int];
    logic [7:0]  ref_mem [int];
    int          we_low = 0, sel_run = 0;

    sram_cycle_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .standby_req(standby_req),
        .busy(busy), .done(done), .rdata(rdata), .mem_addr(mem_addr),
        .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_cs1_n(mem_cs1_n),
        .mem_cs2(mem_cs2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_din(mem_din)
    );

    always #(CLK_NS / 2) clk = ~clk;

    function automatic logic [7:0] init_val(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {7'b0, a[16]};
    endfunction

    function automatic exp_t mk(input logic [6:0] p, input logic [16:0] a,
                                input logic [7:0] d, input string t);
        exp_t e;
        e.pins = p; e.addr = a; e.dout = d; e.set_rd = 1'b0; e.rd = 8'h00; e.tag = t;
        return e;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // Expected-pin model, one step per clock edge.
    always @(posedge clk) begin
        cyc++;
        started = 1;
        acc_evt = 0;
        if (!rst_n) begin
            q.delete();
            in_sb = 0;
            exp_rdata = 8'h00;
            cur = mk(P_IDLE, 17'h0, 8'h0, "R1");
        end else if (q.size() > 0) begin
            cur = q.pop_front();
        end else if (in_sb) begin
            if (!standby_req) begin
                in_sb = 0;
                for (int i = 0; i < RCMIN; i++) q.push_back(mk(P_SB, 17'h0, 8'h0, "R10"));
                cur = q.pop_front();
            end else begin
                cur = mk(P_SB, 17'h0, 8'h0, "R9");
            end
        end else if (last_busy) begin
            cur = mk(P_IDLE, 17'h0, 8'h0, "R10");
        end else if (standby_req) begin
            in_sb = 1;
            cur = mk(P_SB, 17'h0, 8'h0, "R9");
        end else if (req) begin
            exp_t e;
            acc_evt = 1;
            if (req_write) begin
                ref_mem[int'(req_addr)] = req_wdata;
                q.push_back(mk(P_WSET, req_addr, req_wdata, "R5"));
                for (int i = 0; i < WPN; i++) q.push_back(mk(P_WPUL, req_addr, req_wdata, "R5"));
                for (int i = 0; i < WEN; i++) q.push_back(mk(P_WSET, req_addr, req_wdata, "R6"));
                q.push_back(mk(P_DONE, 17'h0, 8'h0, "R7"));
            end else begin
                for (int i = 0; i < RDN + 1; i++) q.push_back(mk(P_RD, req_addr, 8'h0, "R3"));
                e = mk(P_DONE, 17'h0, 8'h0, "R4");
                e.set_rd = 1'b1;
                e.rd = ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : init_val(req_addr);
                q.push_back(e);
            end
            cur = q.pop_front();
        end else begin
            cur = mk(P_IDLE, 17'h0, 8'h0, "R2");
        end
        if (cur.set_rd) exp_rdata = cur.rd;
        last_busy = cur.pins[6];
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Comparison, RAM model and strobe-width monitor, away from the edge.
    always @(negedge clk) begin
        if (started) begin
            chk(cur.tag, "pins{busy,done,cs1_n,cs2,we_n,oe_n,doe}",
                32'({busy, done, mem_cs1_n, mem_cs2, mem_we_n, mem_oe_n, mem_doe}), 32'(cur.pins));
            if (cur.pins[4] == 1'b0) chk("R11", "mem_addr", 32'(mem_addr), 32'(cur.addr));
            if (cur.pins[0] == 1'b1) chk("R11", "mem_dout", 32'(mem_dout), 32'(cur.dout));
            chk("R4", "rdata", 32'(rdata), 32'(exp_rdata));
            if (rst_n) begin
                if (mem_we_n && we_low > 0) begin
                    chk("R6", "we pulse >= min", 32'(we_low >= WPMIN && we_low >= DWMIN), 32'd1);
                    chk("R6", "select to end of write >= min", 32'(sel_run >= CWMIN), 32'd1);
                    we_low = 0;
                end
                if (!mem_we_n) we_low++;
                if (!mem_cs1_n && mem_cs2) sel_run++;
                else begin
                    if (sel_run > 0) chk("R6", "select window >= cycle", 32'(sel_run >= RCMIN), 32'd1);
                    sel_run = 0;
                end
            end
        end
        if (!mem_cs1_n && mem_cs2 && !mem_we_n && mem_doe) ram[int'(mem_addr)] = mem_dout;
        if (!mem_cs1_n && mem_cs2 && mem_we_n && !mem_oe_n)
            mem_din <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : init_val(mem_addr);
        else
            mem_din <= 8'h00;
    end

    task automatic access(input logic w, input logic [16:0] a, input logic [7:0] d,
                          output logic [7:0] rd);
        @(negedge clk);
        req = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        do @(negedge clk); while (!acc_evt);
        req = 1'b0; req_addr = ~a; req_wdata = ~d;
        do @(negedge clk); while (!done);
        rd = rdata;
    endtask

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R5 writes at address extremes and patterns.
        access(1'b1, 17'h00000, 8'hA5, r);
        access(1'b1, 17'h1FFFF, 8'h5A, r);
        access(1'b1, 17'h0AAAA, 8'hFF, r);
        // R3/R4 read back and read of untouched location.
        access(1'b0, 17'h1FFFF, 8'h00, r);
        chk("R4", "readback 1FFFF", 32'(r), 32'h5A);
        access(1'b0, 17'h00000, 8'h00, r);
        chk("R4", "readback 00000", 32'(r), 32'hA5);
        access(1'b0, 17'h12345, 8'h00, r);
        chk("R4", "untouched word", 32'(r), 32'(init_val(17'h12345)));
        // R8: request raised while busy, withdrawn before idle.
        @(negedge clk);
        req = 1'b1; req_write = 1'b1; req_addr = 17'h00100; req_wdata = 8'h3C;
        do @(negedge clk); while (!acc_evt);
        req_addr = 17'h00200; req_wdata = 8'hEE;
        repeat (3) @(negedge clk);
        req = 1'b0;
        do @(negedge clk); while (!done);
        access(1'b0, 17'h00200, 8'h00, r);
        chk("R8", "ignored request left word", 32'(r), 32'(init_val(17'h00200)));
        access(1'b0, 17'h00100, 8'h00, r);
        chk("R8", "accepted write", 32'(r), 32'h3C);
        // R7: back-to-back accesses with req held high.
        @(negedge clk);
        req = 1'b1; req_write = 1'b1; req_addr = 17'h00300; req_wdata = 8'h81;
        do @(negedge clk); while (!done);
        req_write = 1'b0;
        do @(negedge clk); while (!acc_evt);
        req = 1'b0;
        do @(negedge clk); while (!done);
        chk("R7", "back-to-back read", 32'(rdata), 32'h81);
        // R9/R10: standby wins over a pending read, then recovery.
        @(negedge clk);
        standby_req = 1'b1; req = 1'b1; req_write = 1'b0; req_addr = 17'h0AAAA;
        repeat (6) @(negedge clk);
        chk("R9", "busy in standby", 32'(busy), 32'd1);
        standby_req = 1'b0;
        do @(negedge clk); while (!acc_evt);
        req = 1'b0;
        do @(negedge clk); while (!done);
        chk("R10", "read after recovery", 32'(rdata), 32'hFF);
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule